// File: doc/BRIEF.md
# QPSK Phase-Zone Demodulator with Detector Gating

This block recovers QPSK symbols from an IF signal without any multiplier or ADC. It runs on the IF clock and registers an eight-phase bus, taken from a frequency divider, on every rising edge. Inside the sampled word it looks for the single place where a high phase is followed by a low phase, searching around the ring. That place shows which of four quarter-circle zones the IF edge fell in, and the zone gives the two-bit symbol.

A per-symbol sequencer splits each symbol of `SYM_CYCLES` IF cycles into three stretches. During the demodulation stretch the samples are gathered. During the setup stretch the phase-select multiplexer settles. During the active stretch the gating pulse lets the external phase detector compare. A run-length filter accepts a zone only once it has been seen on several consecutive demodulation samples. At each symbol boundary the accepted zone is published as I/Q together with a one-cycle valid strobe.

In acquisition mode the multiplexer select stays on one fixed phase. In tracking mode it points at the odd phase in the middle of the last accepted zone.

The sequencer has three states. `SYM_DEMOD` covers cycles 0 to `DEMOD_CYCLES`-1 and moves to `SYM_SETUP` on its last cycle. `SYM_SETUP` covers the next `SETUP_CYCLES` cycles and moves to `SYM_ACTIVE` on its last cycle. `SYM_ACTIVE` runs to cycle `SYM_CYCLES`-1 and then wraps back to `SYM_DEMOD`, which is also the state after reset. With the defaults, cycles 0–7 are demodulation, 8–11 are setup and 12–15 are active.

Top module: `qpsk_zone_demod`

## Requirements
- R1: While reset is asserted and before the first clock edge after release, `iq` is 00, `iq_valid` is 0 and `gate_pulse` is 0. With `track_mode` low, `mux_sel` equals `ACQ_PHASE` (default 0).
- R2: Count the cycles of a symbol from 0, starting at the first edge after reset. `gate_pulse` is low in cycles 0 to 11 and high in cycles 12 to 15, then the pattern repeats every 16 cycles.
- R3: `iq_valid` is high for exactly one cycle per symbol, in cycle 0 of the following symbol, and low in every other cycle.
- R4: Let bit k of the sampled bus be the phase k sample. The zone is j/2 (integer division), where j is the one index with bit j = 1 and bit (j+1) mod 8 = 0.
- R5: Zones 0, 1, 2 and 3 (I to IV) are output as `iq` = 00, 01, 11 and 10 respectively.
- R6: A sample that does not have exactly one 1-to-0 transition (for example all zeros, all ones, or alternating bits) is not a zone. It also ends any run in progress.
- R7: A zone is accepted only after 3 consecutive demodulation samples of the same symbol decode to it. If no zone is accepted in a symbol, `iq` and the tracking select keep their earlier values.
- R8: Samples taken in cycles 8 to 15 of a symbol take no part in acceptance. A run does not carry from one symbol into the next.
- R9: With `track_mode` low, `mux_sel` equals `ACQ_PHASE`, whatever the data.
- R10: With `track_mode` high, `mux_sel` is 2·z+1, where z is the most recently published zone (0 after reset). It follows `track_mode` within the same cycle.
- R11: If several runs reach 3 within one symbol, the zone of the last run to reach 3 is published.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_if | input | 1 | IF-derived clock; phases sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase_bus | input | 8 | Divider phases, bit k is phase k |
| track_mode | input | 1 | 0 = acquisition (fixed select), 1 = tracking |
| iq | output | 2 | Demodulated symbol bits {I,Q} |
| iq_valid | output | 1 | One-cycle strobe at each symbol boundary |
| mux_sel | output | 3 | Phase index for the phase-detector multiplexer |
| gate_pulse | output | 1 | High while the phase detector may compare |

## Verification
The bench builds the block with its defaults: 16 cycles per symbol, 8 demodulation and 4 setup cycles, and a run length of 3. At that size every one of the 256 sampled bus values can be held for a whole symbol in about four thousand cycles. This covers all valid and invalid patterns and every transition position. Short cycle-by-cycle sequences then probe run breaks, late runs, samples in the setup window, and switching between the two modes.

// File: rtl/qzd_pkg.sv
package qzd_pkg;
    localparam int NPHASE = 8;
    localparam int PW     = $clog2(NPHASE);
    localparam int ZW     = PW - 1;

    typedef enum logic [1:0] {
        SYM_DEMOD  = 2'd0,
        SYM_SETUP  = 2'd1,
        SYM_ACTIVE = 2'd2
    } sym_state_e;

    typedef struct packed {
        logic          ok;
        logic [ZW-1:0] zone;
    } zone_sample_t;

    // Gray order: zone 0..3 -> 00, 01, 11, 10
    function automatic logic [1:0] zone_to_iq(input logic [ZW-1:0] z);
        return {z[1], z[1] ^ z[0]};
    endfunction
endpackage

// File: rtl/qzd_symbol_timer.sv
module qzd_symbol_timer
    import qzd_pkg::*;
#(
    parameter int SYM_CYCLES   = 16,
    parameter int DEMOD_CYCLES = 8,
    parameter int SETUP_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic in_demod_o,
    output logic sym_end_o,
    output logic gate_o
);
    localparam int CW = $clog2(SYM_CYCLES);
    localparam logic [CW-1:0] LAST_DEMOD = CW'(DEMOD_CYCLES - 1);
    localparam logic [CW-1:0] LAST_SETUP = CW'(DEMOD_CYCLES + SETUP_CYCLES - 1);
    localparam logic [CW-1:0] LAST_CYC   = CW'(SYM_CYCLES - 1);

    sym_state_e    state, state_nxt;
    logic [CW-1:0] cnt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= SYM_DEMOD;
            cnt   <= '0;
        end else begin
            state <= state_nxt;
            cnt   <= (cnt == LAST_CYC) ? '0 : cnt + 1'b1;
        end
    end

    // transitions
    always_comb begin
        state_nxt = state;
        unique case (state)
            SYM_DEMOD:  if (cnt == LAST_DEMOD) state_nxt = SYM_SETUP;
            SYM_SETUP:  if (cnt == LAST_SETUP) state_nxt = SYM_ACTIVE;
            SYM_ACTIVE: if (cnt == LAST_CYC)   state_nxt = SYM_DEMOD;
            default:                           state_nxt = SYM_DEMOD;
        endcase
    end

    // outputs
    always_comb begin
        in_demod_o = (state == SYM_DEMOD);
        gate_o     = (state == SYM_ACTIVE);
        sym_end_o  = (state == SYM_ACTIVE) && (cnt == LAST_CYC);
    end
endmodule

// File: rtl/qzd_zone_decode.sv
module qzd_zone_decode
    import qzd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPHASE-1:0] phase_i,
    input  logic              in_demod_i,
    output zone_sample_t      smp_o,
    output logic              smp_demod_o
);
    logic [NPHASE-1:0] samp;
    logic [NPHASE-1:0] fall;
    logic [PW-1:0]     idx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            samp        <= '0;
            smp_demod_o <= 1'b0;
        end else begin
            samp        <= phase_i;
            smp_demod_o <= in_demod_i;
        end
    end

    // circular 1->0 edge detector
    for (genvar k = 0; k < NPHASE; k++) begin : g_edge
        assign fall[k] = samp[k] & ~samp[(k + 1) % NPHASE];
    end

    always_comb begin
        idx = '0;
        for (int k = 0; k < NPHASE; k++) begin
            if (fall[k]) idx = PW'(k);
        end
        smp_o.ok   = $onehot(fall);
        smp_o.zone = idx[PW-1:1];
    end
endmodule

// File: rtl/qzd_confidence.sv
module qzd_confidence
    import qzd_pkg::*;
#(
    parameter int CONFIRM_RUN = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  zone_sample_t  smp_i,
    input  logic          smp_demod_i,
    input  logic          sym_end_i,
    output logic          hit_o,
    output logic [ZW-1:0] zone_o
);
    localparam int RW = $clog2(CONFIRM_RUN + 1);
    localparam logic [RW-1:0] FULL = RW'(CONFIRM_RUN);

    logic [RW-1:0] run_len, len_nxt;
    logic [ZW-1:0] run_zone;
    logic          match, reach;

    always_comb begin
        match = smp_i.ok && (run_len != '0) && (smp_i.zone == run_zone);
        if (!smp_i.ok)            len_nxt = '0;
        else if (!match)          len_nxt = RW'(1);
        else if (run_len == FULL) len_nxt = run_len;
        else                      len_nxt = run_len + 1'b1;
        reach = smp_i.ok && (len_nxt == FULL) && !(match && run_len == FULL);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_len  <= '0;
            run_zone <= '0;
            hit_o    <= 1'b0;
            zone_o   <= '0;
        end else if (sym_end_i) begin
            run_len <= '0;
            hit_o   <= 1'b0;
        end else if (smp_demod_i) begin
            run_len  <= len_nxt;
            run_zone <= smp_i.zone;
            if (reach) begin
                hit_o  <= 1'b1;
                zone_o <= smp_i.zone;
            end
        end
    end
endmodule

// File: rtl/qpsk_zone_demod.sv
module qpsk_zone_demod
    import qzd_pkg::*;
#(
    parameter int SYM_CYCLES   = 16,
    parameter int DEMOD_CYCLES = 8,
    parameter int SETUP_CYCLES = 4,
    parameter int CONFIRM_RUN  = 3,
    parameter int ACQ_PHASE    = 0
) (
    input  logic              clk_if,
    input  logic              rst_n,
    input  logic [NPHASE-1:0] phase_bus,
    input  logic              track_mode,
    output logic [1:0]        iq,
    output logic              iq_valid,
    output logic [PW-1:0]     mux_sel,
    output logic              gate_pulse
);
    localparam logic [PW-1:0] ACQ_SEL = PW'(ACQ_PHASE);

    logic          in_demod, sym_end, hit, smp_demod;
    logic [ZW-1:0] conf_zone, zone_q;
    zone_sample_t  smp;

    qzd_symbol_timer #(
        .SYM_CYCLES  (SYM_CYCLES),
        .DEMOD_CYCLES(DEMOD_CYCLES),
        .SETUP_CYCLES(SETUP_CYCLES)
    ) u_timer (
        .clk       (clk_if),
        .rst_n     (rst_n),
        .in_demod_o(in_demod),
        .sym_end_o (sym_end),
        .gate_o    (gate_pulse)
    );

    qzd_zone_decode u_decode (
        .clk        (clk_if),
        .rst_n      (rst_n),
        .phase_i    (phase_bus),
        .in_demod_i (in_demod),
        .smp_o      (smp),
        .smp_demod_o(smp_demod)
    );

    qzd_confidence #(.CONFIRM_RUN(CONFIRM_RUN)) u_conf (
        .clk        (clk_if),
        .rst_n      (rst_n),
        .smp_i      (smp),
        .smp_demod_i(smp_demod),
        .sym_end_i  (sym_end),
        .hit_o      (hit),
        .zone_o     (conf_zone)
    );

    always_ff @(posedge clk_if or negedge rst_n) begin
        if (!rst_n) begin
            iq       <= '0;
            iq_valid <= 1'b0;
            zone_q   <= '0;
        end else begin
            iq_valid <= sym_end;
            if (sym_end && hit) begin
                iq     <= zone_to_iq(conf_zone);
                zone_q <= conf_zone;
            end
        end
    end

    always_comb begin
        mux_sel = track_mode ? {zone_q, 1'b1} : ACQ_SEL;
    end
endmodule

// File: rtl/qzd_checker.sv
module qzd_checker #(
    parameter int SYM_CYCLES   = 16,
    parameter int DEMOD_CYCLES = 8,
    parameter int SETUP_CYCLES = 4,
    parameter int ACQ_PHASE    = 0
) (
    input logic       clk_if,
    input logic       rst_n,
    input logic       track_mode,
    input logic [1:0] iq,
    input logic       iq_valid,
    input logic [2:0] mux_sel,
    input logic       gate_pulse
);
    localparam int CW = $clog2(SYM_CYCLES);
    localparam logic [CW-1:0] LAST_CYC  = CW'(SYM_CYCLES - 1);
    localparam logic [CW-1:0] ACT_FIRST = CW'(DEMOD_CYCLES + SETUP_CYCLES);

    logic [CW-1:0] ccnt;

    always_ff @(posedge clk_if or negedge rst_n) begin
        if (!rst_n) ccnt <= '0;
        else        ccnt <= (ccnt == LAST_CYC) ? '0 : ccnt + 1'b1;
    end

    p_gate_window_r2: assert property (@(posedge clk_if) disable iff (!rst_n)
        gate_pulse == (ccnt >= ACT_FIRST));

    p_valid_slot_r3: assert property (@(posedge clk_if) disable iff (!rst_n)
        iq_valid |-> (ccnt == '0));

    p_valid_single_r3: assert property (@(posedge clk_if) disable iff (!rst_n)
        iq_valid |=> !iq_valid);

    p_iq_hold_r7: assert property (@(posedge clk_if) disable iff (!rst_n)
        !$stable(iq) |-> iq_valid);

    p_mux_acq_r9: assert property (@(posedge clk_if) disable iff (!rst_n)
        !track_mode |-> (mux_sel == 3'(ACQ_PHASE)));

    p_mux_track_r10: assert property (@(posedge clk_if) disable iff (!rst_n)
        track_mode |-> (mux_sel == {iq[1], iq[1] ^ iq[0], 1'b1}));
endmodule

bind qpsk_zone_demod qzd_checker #(
    .SYM_CYCLES  (SYM_CYCLES),
    .DEMOD_CYCLES(DEMOD_CYCLES),
    .SETUP_CYCLES(SETUP_CYCLES),
    .ACQ_PHASE   (ACQ_PHASE)
) u_chk (
    .clk_if    (clk_if),
    .rst_n     (rst_n),
    .track_mode(track_mode),
    .iq        (iq),
    .iq_valid  (iq_valid),
    .mux_sel   (mux_sel),
    .gate_pulse(gate_pulse)
);

// File: tb/qpsk_zone_demod_bench.sv
`timescale 1ns/1ps
module qpsk_zone_demod_bench;
    logic       clk_if = 1'b0;
    logic       rst_n;
    logic [7:0] phase_bus;
    logic       track_mode;
    logic [1:0] iq;
    logic       iq_valid;
    logic [2:0] mux_sel;
    logic       gate_pulse;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    logic [7:0] sym_pat [16];
    int exp_zone = 0;

    always #2 clk_if = ~clk_if;

    qpsk_zone_demod u_qpsk_zone_demod (
        .clk_if    (clk_if),
        .rst_n     (rst_n),
        .phase_bus (phase_bus),
        .track_mode(track_mode),
        .iq        (iq),
        .iq_valid  (iq_valid),
        .mux_sel   (mux_sel),
        .gate_pulse(gate_pulse)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    function automatic logic [7:0] pat_at(input int j);
        logic [7:0] p = '0;
        for (int m = 0; m < 4; m++) p[(j - m + 8) % 8] = 1'b1;
        return p;
    endfunction

    function automatic int zone_of(input logic [7:0] p);
        int cnt = 0;
        int j = 0;
        for (int k = 0; k < 8; k++)
            if (p[k] && !p[(k + 1) % 8]) begin cnt++; j = k; end
        return (cnt == 1) ? j / 2 : -1;
    endfunction

    function automatic int gray_of(input int z);
        case (z)
            0: return 0;
            1: return 1;
            2: return 3;
            default: return 2;
        endcase
    endfunction

    // drive one symbol from sym_pat, then check the published result
    task automatic run_symbol(input string req);
        int run_z = -1, run = 0, conf = -1;
        for (int c = 0; c < 16; c++) begin
            phase_bus = sym_pat[c];
            chk(gate_pulse == (c >= 12), "R2", "gate_pulse", gate_pulse, c >= 12);
            if (c == 8) chk(iq_valid == 1'b0, "R3", "iq_valid mid-symbol", iq_valid, 0);
            if (c < 8) begin
                int d = zone_of(sym_pat[c]);
                if (d < 0) run = 0;
                else if (run > 0 && d == run_z) run++;
                else begin run_z = d; run = 1; end
                if (run == 3) conf = d;
            end
            @(negedge clk_if);
        end
        if (conf >= 0) exp_zone = conf;
        chk(iq_valid == 1'b1, "R3", "iq_valid at boundary", iq_valid, 1);
        chk(iq == 2'(gray_of(exp_zone)), req, "iq", iq, gray_of(exp_zone));
        if (track_mode)
            chk(mux_sel == 3'(2 * exp_zone + 1), "R10", "mux_sel track", mux_sel, 2 * exp_zone + 1);
        else
            chk(mux_sel == 3'd0, "R9", "mux_sel acq", mux_sel, 0);
    endtask

    task automatic fill(input logic [7:0] p);
        for (int c = 0; c < 16; c++) sym_pat[c] = p;
    endtask

    initial begin
        #(4ns * 150000);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        phase_bus = 8'h00;
        track_mode = 1'b0;
        repeat (3) @(negedge clk_if);
        chk(iq == 2'b00, "R1", "iq in reset", iq, 0);
        chk(iq_valid == 1'b0, "R1", "iq_valid in reset", iq_valid, 0);
        chk(gate_pulse == 1'b0, "R1", "gate in reset", gate_pulse, 0);
        chk(mux_sel == 3'd0, "R1", "mux_sel in reset", mux_sel, 0);
        rst_n = 1'b1;
        chk(iq_valid == 1'b0, "R1", "iq_valid after release", iq_valid, 0);

        // R9: acquisition mode, data present
        fill(pat_at(5));
        run_symbol("R5");
        chk(mux_sel == 3'd0, "R9", "mux_sel acq with data", mux_sel, 0);

        // R10: switch to tracking, select follows same cycle
        track_mode = 1'b1;
        #0.1;
        chk(mux_sel == 3'd5, "R10", "mux_sel after switch", mux_sel, 5);

        // R4 R5 R6: exhaustive sweep of the sampled bus
        for (int p = 0; p < 256; p++) begin
            fill(8'(p));
            run_symbol(zone_of(8'(p)) < 0 ? "R6" : "R4");
        end

        // R7: alternating zones never reach a run of 3
        fill(pat_at(4));
        run_symbol("R5");
        for (int c = 0; c < 16; c++) sym_pat[c] = pat_at((c % 2) ? 1 : 6);
        run_symbol("R7");

        // R11: two runs reach 3, later one wins
        for (int c = 0; c < 16; c++) sym_pat[c] = 8'hFF;
        for (int c = 0; c < 3; c++) sym_pat[c] = pat_at(2);
        for (int c = 3; c < 6; c++) sym_pat[c] = pat_at(7 - (c % 2));
        run_symbol("R11");

        // R6: an invalid sample breaks the run
        fill(8'h00);
        sym_pat[0] = pat_at(0); sym_pat[1] = pat_at(1); sym_pat[2] = 8'b1010_1010;
        sym_pat[3] = pat_at(0); sym_pat[4] = pat_at(1);
        run_symbol("R6");

        // R8: setup/active samples do not count
        fill(pat_at(2));
        for (int c = 0; c < 6; c++) sym_pat[c] = 8'h00;
        sym_pat[6] = pat_at(4); sym_pat[7] = pat_at(5);
        for (int c = 8; c < 16; c++) sym_pat[c] = pat_at(4);
        run_symbol("R8");
        // run must not carry across the symbol boundary
        fill(8'hFF);
        sym_pat[0] = pat_at(4);
        run_symbol("R8");
        fill(pat_at(1));
        for (int c = 0; c < 5; c++) sym_pat[c] = 8'h00;
        for (int c = 8; c < 16; c++) sym_pat[c] = pat_at(6);
        run_symbol("R8");

        // R9 again: back to acquisition
        track_mode = 1'b0;
        #0.1;
        chk(mux_sel == 3'd0, "R9", "mux_sel back to acq", mux_sel, 0);
        fill(pat_at(7));
        run_symbol("R5");

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule